// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular buffer that holds the instructions a processor has in flight, in the order the program issued them. Decode writes one instruction per cycle through the allocation port. It supplies the destination logical register, the newly mapped physical register, the physical register the destination used before, the instruction address and whether the instruction is a branch. The block returns the slot number (tag) that the instruction occupies. Execution units later report completion against that tag, together with an exception flag and a branch-mispredict flag.

Retirement happens only at the oldest slot. At most one instruction leaves per cycle, and only once it has completed cleanly. The retired logical register and both physical registers are presented so that the architectural map can be updated and the previous physical register returned to the free pool. A faulting instruction is held until it becomes the oldest. The block then signals the trap with that instruction's address instead of retiring it, and empties itself. A mispredicted branch discards every younger instruction in the cycle its completion arrives. The branch itself stays and retires normally.

The depth must be a power of two. Each retirement frees exactly one slot for a later allocation.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready`=1, `alloc_tag`=0, `cmt_valid`=0, `exc_valid`=0.
- R2: Accepted allocations receive consecutive tags modulo DEPTH (tag = slot index 0..DEPTH-1). `alloc_tag` always shows the tag that the next accepted allocation will receive.
- R3: When DEPTH entries are in flight, `alloc_ready` is 0 and an asserted `alloc_valid` is ignored: `alloc_tag` does not move and no entry is added.
- R4: The oldest entry retires only after it has completed without an exception. At most one entry retires per cycle. One cycle after the decision, `cmt_valid` pulses with that entry's logical, new and old physical registers. A younger completion never retires ahead of an older entry that has not completed.
- R5: An entry completed with the exception flag is not acted on until it is the oldest. Then `exc_valid` pulses for one cycle with its `exc_pc`, the entry does not retire, all entries are discarded, and `alloc_tag` returns to the faulting tag.
- R6: A completion with the mispredict flag set on a valid branch entry discards all younger entries at once. From the next cycle `alloc_tag` equals branch tag + 1. An allocation offered in that same cycle is not accepted. Discarded entries never retire.
- R7: A completion whose tag names an empty (never allocated or discarded) slot is ignored.
- R8: Retiring an entry from a full buffer makes `alloc_ready` return to 1.
- R9: The mispredict flag is ignored for an entry allocated with `alloc_is_br`=0. That entry is only marked completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_lreg | input | LREG_W | Destination logical register |
| alloc_new_preg | input | PREG_W | Newly mapped physical register |
| alloc_old_preg | input | PREG_W | Previously mapped physical register |
| alloc_is_br | input | 1 | Instruction is a branch |
| alloc_pc | input | PC_W | Instruction address |
| alloc_ready | output | 1 | A slot is free |
| alloc_tag | output | IDX_W | Tag the next allocation receives |
| cmp_valid | input | 1 | Completion report |
| cmp_tag | input | IDX_W | Completed entry |
| cmp_exc | input | 1 | Entry raised an exception |
| cmp_mispred | input | 1 | Branch was mispredicted |
| cmt_valid | output | 1 | An entry retired |
| cmt_lreg | output | LREG_W | Retired logical register |
| cmt_new_preg | output | PREG_W | Retired new physical register |
| cmt_old_preg | output | PREG_W | Physical register to release |
| exc_valid | output | 1 | Trap at the oldest entry |
| exc_pc | output | PC_W | Address of the trapping instruction |

## Verification
A wrong head or tail pointer shows on `alloc_tag` in the next cycle. It also shows at the next retirement, as register fields from the wrong slot. A stale valid or done bit shows as a retirement that should not occur or one that never comes, within one cycle of the head reaching that slot. Errors in the discard boundary show as a wrong `alloc_tag` one cycle after the mispredict, or as a wrong-path entry retiring later. A reference model in the bench predicts every port on every cycle, through directed cases for fill, exception and mispredict and through a random mix.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    HEAD_IDLE   = 2'd0,
    HEAD_RETIRE = 2'd1,
    HEAD_TRAP   = 2'd2
  } head_act_e;
endpackage

// File: rtl/rob_payload.sv
module rob_payload #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 49,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rob_flags.sv
module rob_flags #(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] head_idx,
  input  logic             retire,
  input  logic             clr_all,
  input  logic             squash,
  input  logic [IDX_W:0]   keep_cnt,
  input  logic             alloc_fire,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic             alloc_br,
  input  logic             cmp_fire,
  input  logic [IDX_W-1:0] cmp_idx,
  input  logic             cmp_exc,
  output logic [DEPTH-1:0] valid_q,
  output logic [DEPTH-1:0] done_q,
  output logic [DEPTH-1:0] exc_q,
  output logic [DEPTH-1:0] br_q
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [IDX_W-1:0] age;
    logic             keep;
    assign age  = IDX_W'(i) - head_idx;
    assign keep = {1'b0, age} < keep_cnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[i] <= 1'b0;
        done_q[i]  <= 1'b0;
        exc_q[i]   <= 1'b0;
        br_q[i]    <= 1'b0;
      end else if (clr_all) begin
        valid_q[i] <= 1'b0;
      end else begin
        if (retire && head_idx == IDX_W'(i)) valid_q[i] <= 1'b0;
        if (squash && !keep) valid_q[i] <= 1'b0;
        if (alloc_fire && alloc_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          done_q[i]  <= 1'b0;
          exc_q[i]   <= 1'b0;
          br_q[i]    <= alloc_br;
        end
        if (cmp_fire && cmp_idx == IDX_W'(i)) begin
          done_q[i] <= 1'b1;
          exc_q[i]  <= cmp_exc;
        end
      end
    end
  end

  // R5: a trap leaves no entry behind
  p_trap_empties_r5: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> valid_q == '0);

  // R6: after a squash no more entries survive than the kept span
  p_squash_bound_r6: assert property (@(posedge clk) disable iff (rst)
    squash |=> $countones(valid_q) <= int'($past(keep_cnt)));
endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_valid,
  input  logic             cmp_valid,
  input  logic [IDX_W-1:0] cmp_tag,
  input  logic             cmp_mispred,
  input  logic [DEPTH-1:0] valid_q,
  input  logic [DEPTH-1:0] done_q,
  input  logic [DEPTH-1:0] exc_q,
  input  logic [DEPTH-1:0] br_q,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             alloc_ready,
  output logic             alloc_fire,
  output logic             cmp_fire,
  output logic             squash,
  output logic [IDX_W:0]   keep_cnt,
  output head_act_e        head_act
);
  localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

  logic [PTR_W-1:0] head_ptr, tail_ptr, count;
  logic [IDX_W-1:0] tag_age;

  assign head_idx    = head_ptr[IDX_W-1:0];
  assign tail_idx    = tail_ptr[IDX_W-1:0];
  assign count       = tail_ptr - head_ptr;
  assign alloc_ready = count != FULL_CNT;

  always_comb begin
    head_act = HEAD_IDLE;
    if (valid_q[head_idx] && done_q[head_idx])
      head_act = exc_q[head_idx] ? HEAD_TRAP : HEAD_RETIRE;
  end

  assign tag_age    = cmp_tag - head_idx;
  assign keep_cnt   = {1'b0, tag_age} + {{IDX_W{1'b0}}, 1'b1};
  assign cmp_fire   = cmp_valid && valid_q[cmp_tag] && head_act != HEAD_TRAP;
  assign squash     = cmp_fire && cmp_mispred && br_q[cmp_tag];
  assign alloc_fire = alloc_valid && alloc_ready && !squash && head_act != HEAD_TRAP;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_ptr <= '0;
      tail_ptr <= '0;
    end else if (head_act == HEAD_TRAP) begin
      tail_ptr <= head_ptr;
    end else begin
      if (head_act == HEAD_RETIRE) head_ptr <= head_ptr + PTR_W'(1);
      if (squash)
        tail_ptr <= head_ptr + keep_cnt;
      else if (alloc_fire)
        tail_ptr <= tail_ptr + PTR_W'(1);
    end
  end

  // R3: occupancy never exceeds the depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R4: the head moves by at most one slot per cycle
  p_head_step_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (head_ptr == $past(head_ptr)) || (head_ptr == $past(head_ptr) + PTR_W'(1)));
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int LREG_W = 5,
  parameter int PREG_W = 6,
  parameter int PC_W   = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PAY_W = PC_W + LREG_W + 2 * PREG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [LREG_W-1:0] alloc_lreg,
  input  logic [PREG_W-1:0] alloc_new_preg,
  input  logic [PREG_W-1:0] alloc_old_preg,
  input  logic              alloc_is_br,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_tag,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_tag,
  input  logic              cmp_exc,
  input  logic              cmp_mispred,
  output logic              cmt_valid,
  output logic [LREG_W-1:0] cmt_lreg,
  output logic [PREG_W-1:0] cmt_new_preg,
  output logic [PREG_W-1:0] cmt_old_preg,
  output logic              exc_valid,
  output logic [PC_W-1:0]   exc_pc
);
  logic [DEPTH-1:0] valid_q, done_q, exc_q, br_q;
  logic [IDX_W-1:0] head_idx, tail_idx;
  logic             alloc_fire, cmp_fire, squash;
  logic [IDX_W:0]   keep_cnt;
  head_act_e        head_act;
  logic [PAY_W-1:0] wr_pay, rd_pay;
  logic [PC_W-1:0]   rd_pc;
  logic [LREG_W-1:0] rd_lreg;
  logic [PREG_W-1:0] rd_new, rd_old;

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .cmp_mispred(cmp_mispred),
    .valid_q(valid_q), .done_q(done_q), .exc_q(exc_q), .br_q(br_q),
    .head_idx(head_idx), .tail_idx(tail_idx), .alloc_ready(alloc_ready),
    .alloc_fire(alloc_fire), .cmp_fire(cmp_fire), .squash(squash),
    .keep_cnt(keep_cnt), .head_act(head_act)
  );

  rob_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .head_idx(head_idx),
    .retire(head_act == HEAD_RETIRE), .clr_all(head_act == HEAD_TRAP),
    .squash(squash), .keep_cnt(keep_cnt),
    .alloc_fire(alloc_fire), .alloc_idx(tail_idx), .alloc_br(alloc_is_br),
    .cmp_fire(cmp_fire), .cmp_idx(cmp_tag), .cmp_exc(cmp_exc),
    .valid_q(valid_q), .done_q(done_q), .exc_q(exc_q), .br_q(br_q)
  );

  assign wr_pay = {alloc_pc, alloc_lreg, alloc_new_preg, alloc_old_preg};
  assign {rd_pc, rd_lreg, rd_new, rd_old} = rd_pay;

  rob_payload #(.DEPTH(DEPTH), .WIDTH(PAY_W)) u_pay (
    .clk(clk), .we(alloc_fire), .waddr(tail_idx), .wdata(wr_pay),
    .raddr(head_idx), .rdata(rd_pay)
  );

  assign alloc_tag = tail_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmt_valid    <= 1'b0;
      cmt_lreg     <= '0;
      cmt_new_preg <= '0;
      cmt_old_preg <= '0;
      exc_valid    <= 1'b0;
      exc_pc       <= '0;
    end else begin
      cmt_valid <= head_act == HEAD_RETIRE;
      exc_valid <= head_act == HEAD_TRAP;
      if (head_act == HEAD_RETIRE) begin
        cmt_lreg     <= rd_lreg;
        cmt_new_preg <= rd_new;
        cmt_old_preg <= rd_old;
      end
      if (head_act == HEAD_TRAP) exc_pc <= rd_pc;
    end
  end

  // R4/R5: a cycle either retires or traps, never both
  p_commit_trap_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(cmt_valid && exc_valid));

  // R5: a trap pulse lasts one cycle
  p_trap_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    exc_valid |=> !exc_valid);
endmodule

// File: tb/test_rob_core.sv
module test_rob_core;
  localparam int D = 32;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_valid = 0, alloc_is_br = 0;
  logic [4:0] alloc_lreg = 0;
  logic [5:0] alloc_new_preg = 0, alloc_old_preg = 0;
  logic [31:0] alloc_pc = 0;
  logic alloc_ready;
  logic [IW-1:0] alloc_tag;
  logic cmp_valid = 0, cmp_exc = 0, cmp_mispred = 0;
  logic [IW-1:0] cmp_tag = 0;
  logic cmt_valid, exc_valid;
  logic [4:0] cmt_lreg;
  logic [5:0] cmt_new_preg, cmt_old_preg;
  logic [31:0] exc_pc;

  always #4 clk = ~clk;

  rob_core i_rob_core (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_lreg(alloc_lreg),
    .alloc_new_preg(alloc_new_preg), .alloc_old_preg(alloc_old_preg),
    .alloc_is_br(alloc_is_br), .alloc_pc(alloc_pc), .alloc_ready(alloc_ready),
    .alloc_tag(alloc_tag), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .cmp_exc(cmp_exc), .cmp_mispred(cmp_mispred), .cmt_valid(cmt_valid),
    .cmt_lreg(cmt_lreg), .cmt_new_preg(cmt_new_preg), .cmt_old_preg(cmt_old_preg),
    .exc_valid(exc_valid), .exc_pc(exc_pc)
  );

  int checks = 0, errors = 0, cycles = 0;

  // reference model state
  int m_head = 0, m_cnt = 0;
  bit m_done[D], m_exc[D], m_br[D];
  int m_lreg[D], m_new[D], m_old[D], m_pc[D];
  bit e_cmt = 0, e_exc = 0;
  int e_lreg = 0, e_new = 0, e_old = 0, e_pc = 0;

  function automatic int age(int t, int h);
    return (t - h + D) % D;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(alloc_ready == (m_cnt < D), "R3", "alloc_ready", alloc_ready, m_cnt < D);
    chk(alloc_tag == (m_head + m_cnt) % D, "R2", "alloc_tag", alloc_tag, (m_head + m_cnt) % D);
    chk(cmt_valid == e_cmt, "R4", "cmt_valid", cmt_valid, e_cmt);
    if (e_cmt) begin
      chk(cmt_lreg == e_lreg, "R4", "cmt_lreg", cmt_lreg, e_lreg);
      chk(cmt_new_preg == e_new, "R4", "cmt_new_preg", cmt_new_preg, e_new);
      chk(cmt_old_preg == e_old, "R4", "cmt_old_preg", cmt_old_preg, e_old);
    end
    chk(exc_valid == e_exc, "R5", "exc_valid", exc_valid, e_exc);
    if (e_exc) chk(exc_pc == e_pc, "R5", "exc_pc", exc_pc, e_pc);
  endtask

  // one clock: model the edge from current inputs, then compare after it
  task automatic step();
    bit trap, ret, cok, sq, al;
    int slot, ct;
    ct   = int'(cmp_tag);
    trap = m_cnt > 0 && m_done[m_head] && m_exc[m_head];
    ret  = m_cnt > 0 && m_done[m_head] && !m_exc[m_head];
    cok  = cmp_valid && age(ct, m_head) < m_cnt && !trap;
    sq   = cok && cmp_mispred && m_br[ct];
    al   = alloc_valid && m_cnt < D && !sq && !trap;
    e_cmt = ret;
    e_exc = trap;
    if (trap) begin
      e_pc  = m_pc[m_head];
      m_cnt = 0;
    end else begin
      slot = (m_head + m_cnt) % D;
      if (ret) begin
        e_lreg = m_lreg[m_head]; e_new = m_new[m_head]; e_old = m_old[m_head];
      end
      if (cok) begin
        m_done[ct] = 1; m_exc[ct] = cmp_exc;
      end
      if (sq) m_cnt = age(ct, m_head) + 1;
      if (al) begin
        m_done[slot] = 0; m_exc[slot] = 0; m_br[slot] = alloc_is_br;
        m_lreg[slot] = int'(alloc_lreg); m_new[slot] = int'(alloc_new_preg);
        m_old[slot] = int'(alloc_old_preg); m_pc[slot] = int'(alloc_pc);
        m_cnt++;
      end
      if (ret) begin
        m_head = (m_head + 1) % D;
        m_cnt--;
      end
    end
    @(posedge clk);
    @(negedge clk);
    cycles++;
    compare_all();
  endtask

  task automatic set_alloc(int n, bit br);
    alloc_valid = 1; alloc_is_br = br;
    alloc_lreg = 5'(n); alloc_new_preg = 6'(n + 7); alloc_old_preg = 6'(n * 3);
    alloc_pc = 32'h1000 + 32'(n * 4);
  endtask

  task automatic do_alloc(int n, bit br);
    set_alloc(n, br); step(); alloc_valid = 0;
  endtask

  task automatic do_cmp(int t, bit ex, bit mis);
    cmp_valid = 1; cmp_tag = IW'(t); cmp_exc = ex; cmp_mispred = mis;
    step();
    cmp_valid = 0; cmp_exc = 0; cmp_mispred = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    int b, h0, n0, tg;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk(alloc_ready == 1, "R1", "alloc_ready", alloc_ready, 1);
    chk(alloc_tag == 0, "R1", "alloc_tag", alloc_tag, 0);
    chk(cmt_valid == 0 && exc_valid == 0, "R1", "cmt/exc", cmt_valid | exc_valid, 0);

    // R2/R4: in-order retirement with out-of-order completion
    for (int k = 0; k < 4; k++) do_alloc(k + 1, 0);
    do_cmp(2, 0, 0);
    do_cmp(3, 0, 0);
    chk(cmt_valid == 0, "R4", "younger retired early", cmt_valid, 0);
    do_cmp(0, 0, 0);
    do_cmp(1, 0, 0);
    idle(5);

    // R3: fill to full, extra request ignored
    while (m_cnt < D) do_alloc(m_cnt + 10, 0);
    tg = int'(alloc_tag);
    do_alloc(99, 0);
    chk(alloc_ready == 0, "R3", "ready when full", alloc_ready, 0);
    chk(int'(alloc_tag) == tg, "R3", "tag moved when full", alloc_tag, tg);
    // R8: one retirement frees a slot
    do_cmp(m_head, 0, 0);
    idle(1);
    chk(alloc_ready == 1, "R8", "ready after retire", alloc_ready, 1);
    h0 = m_head; n0 = m_cnt;
    for (int k = 0; k < n0; k++) do_cmp((h0 + k) % D, 0, 0);
    idle(4);

    // R5: exception waits for head, then traps and empties
    b = (m_head + m_cnt) % D;
    for (int k = 0; k < 3; k++) do_alloc(40 + k, 0);
    do_cmp((b + 1) % D, 1, 0);
    idle(2);
    chk(exc_valid == 0, "R5", "trap before head", exc_valid, 0);
    do_cmp((b + 2) % D, 0, 0);
    do_cmp(b, 0, 0);
    idle(3);
    chk(int'(alloc_tag) == (b + 1) % D, "R5", "tag after trap", alloc_tag, (b + 1) % D);

    // R6: mispredict discards younger entries, same-cycle allocation refused
    b = (m_head + m_cnt) % D;
    do_alloc(50, 0);
    do_alloc(51, 1);
    for (int k = 0; k < 3; k++) do_alloc(52 + k, 0);
    do_cmp((b + 3) % D, 0, 0);
    set_alloc(60, 0);
    do_cmp((b + 1) % D, 0, 1);
    alloc_valid = 0;
    chk(int'(alloc_tag) == (b + 2) % D, "R6", "tag after squash", alloc_tag, (b + 2) % D);
    // R7: completion of a discarded entry is ignored
    do_cmp((b + 3) % D, 0, 0);
    do_cmp((b + 4) % D, 0, 0);
    chk(int'(alloc_tag) == (b + 2) % D, "R7", "tag after stale cmp", alloc_tag, (b + 2) % D);
    do_cmp(b, 0, 0);
    idle(4);
    chk(m_cnt == 0 && int'(alloc_tag) == (b + 2) % D, "R6", "drained tag", alloc_tag, (b + 2) % D);

    // R9: mispredict on a non-branch does not discard
    b = (m_head + m_cnt) % D;
    for (int k = 0; k < 3; k++) do_alloc(70 + k, 0);
    do_cmp(b, 0, 1);
    chk(int'(alloc_tag) == (b + 3) % D, "R9", "tag after non-branch mispred", alloc_tag, (b + 3) % D);
    do_cmp((b + 1) % D, 0, 0);
    do_cmp((b + 2) % D, 0, 0);
    idle(4);

    // mixed random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 2) != 0) set_alloc($urandom_range(0, 31), $urandom_range(0, 3) == 0);
      else alloc_valid = 0;
      cmp_valid = $urandom_range(0, 1) == 1;
      cmp_tag = IW'((m_head + $urandom_range(0, D - 1)) % D);
      cmp_exc = $urandom_range(0, 40) == 0;
      cmp_mispred = $urandom_range(0, 8) == 0;
      step();
    end
    alloc_valid = 0; cmp_valid = 0; cmp_exc = 0; cmp_mispred = 0;
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule